// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single capture/compare unit that sits beside a shared 16-bit timer counter. It does not count by itself. Each cycle it receives the counter value, the count direction, an up/down operating flag, and the compare value held by the first channel of the timer. Software reaches it through a byte-wide port with three registers: a control byte, and the low and high bytes of a 16-bit value register.

In capture mode the unit watches a pin, or a radio-event line chosen by a control bit. It synchronizes the selected line, finds the edges picked by the edge field, and on each qualifying edge stores the counter in the value register. In compare mode it drives an output pin. When the counter meets the stored value, or meets the channel-zero value or zero, it applies one of several actions: set, clear, toggle, direction-aware set/clear, or window forms. Every capture or match raises a sticky flag. The interrupt line is that flag gated by an enable bit.

In compare mode, new values are staged. A low-byte write is held back until a high-byte write follows. The combined word then waits until the counter passes through zero, so a compare point never changes partway through a period.

Top module: `tcc_channel`

## Requirements
- R1: After reset the control byte reads 0x40, both value bytes read 0x00, and the output pin and the interrupt line are 0.
- R2: The control byte holds, from bit 7 down: radio-source select (bit 7), interrupt enable (bit 6), compare action (bits 5:3), mode (bit 2, 1 = compare), edge select (bits 1:0). The register select code is 0 = control, 1 = value low byte, 2 = value high byte, and 3 reads as zero. Values written to the control byte read back unchanged, except as R8 states.
- R3: In capture mode the edge select works as follows: 00 ignores the input, 01 captures on rising edges, 10 on falling edges, 11 on both. A capture copies the current counter into the value register.
- R4: With bit 7 set, the radio-event line replaces the capture pin. Edges on the line that is not selected cause no capture.
- R5: Compare action 000 sets the output, 001 clears it and 010 inverts it, each when the counter equals the stored value.
- R6: With up/down operation active, action 011 sets the output on a match while counting up and clears it on a match while counting down. Without up/down operation it sets on a match and clears when the counter is 0. Action 100 does the same with set and clear swapped.
- R7: Action 101 clears the output when the counter equals the channel-zero value and sets it on its own match. Action 110 does the opposite. When both matches fall on the same counter value, the channel's own match decides.
- R8: A control write whose action field is 111 drives the output to 0. The stored action stays as it was, and the other fields are written.
- R9: A low-byte write goes into a holding buffer and is not visible in the value register until a later high-byte write moves both bytes in.
- R10: In capture mode a high-byte write updates the value register at once.
- R11: In compare mode a high-byte write is staged. The value register changes only when the counter is 0x0000.
- R12: A capture or a compare match sets a sticky flag. The interrupt line is the flag AND the enable bit, and a clear strobe resets the flag.
- R13: A counter value that stays unchanged for several cycles produces only one compare event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt | input | 16 | Shared timer counter value |
| cnt_down | input | 1 | 1 while the counter is counting down |
| updown_mode | input | 1 | 1 when the timer runs up/down |
| ref0_val | input | 16 | Compare value of channel zero |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| radio_evt | input | 1 | Alternate capture source, synchronous to clk |
| flag_clr | input | 1 | Clears the event flag |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every compare action against counter ramps, both in plain up-counting and in up/down operation, and checks the pin on every step. A design that mixed up the direction rule for 011/100, or cleared on zero during up/down counting, would show a wrong pin level on the falling part of the ramp. A further run puts the channel-zero value on the channel's own value, so that getting the window priority wrong flips the pin. Holding the counter on the match value shows whether a toggle fires once or several times. The staging tests write the value bytes with the counter away from zero and read them back before and after zero. This catches a design that updates early or lets the low byte through alone. The capture sweep covers every edge code and both sources, so a swapped edge decode or a source that leaks through shows up as a wrong captured word or a stray interrupt.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   typedef enum logic [2:0] {
      ACT_SET     = 3'd0,
      ACT_CLR     = 3'd1,
      ACT_TGL     = 3'd2,
      ACT_DIR_SET = 3'd3,
      ACT_DIR_CLR = 3'd4,
      ACT_WIN_SET = 3'd5,
      ACT_WIN_CLR = 3'd6,
      ACT_INIT    = 3'd7
   } act_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_e;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_NONE = 2'd3
   } rsel_e;

   typedef struct packed {
      logic  alt_src;
      logic  ie;
      act_e  act;
      logic  cmp_mode;
      edge_e edge_sel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam ctrl_t CTRL_RST = '{alt_src: 1'b0, ie: 1'b1, act: ACT_SET,
                                  cmp_mode: 1'b0, edge_sel: EDGE_NONE};

endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tcc_capture.sv
module tcc_capture
   import tcc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_SYNC    = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin,
   input  logic  alt,
   input  logic  use_alt,
   input  edge_e edge_sel,
   input  logic  enable,
   output logic  evt
);

   logic pin_s;
   logic alt_s;
   logic src_s;
   logic prev_q;
   logic rise;
   logic fall;

   tcc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin),
      .q    (pin_s)
   );

   generate
      if (ALT_SYNC) begin : g_alt_sync
         tcc_sync #(.STAGES(SYNC_STAGES)) u_alt_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (alt),
            .q    (alt_s)
         );
      end else begin : g_alt_direct
         assign alt_s = alt;
      end
   endgenerate

   assign src_s = use_alt ? alt_s : pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= src_s;
   end

   assign rise = src_s & ~prev_q;
   assign fall = ~src_s & prev_q;

   always_comb begin
      evt = 1'b0;
      case (edge_sel)
         EDGE_RISE: evt = rise;
         EDGE_FALL: evt = fall;
         EDGE_BOTH: evt = rise | fall;
         default:   evt = 1'b0;
      endcase
      evt = evt & enable;
   end

endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
   import tcc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_down,
   input  logic             updown,
   input  logic [CNT_W-1:0] own_val,
   input  logic [CNT_W-1:0] ref0_val,
   input  act_e             act,
   input  logic             active,
   input  logic             init,
   output logic             out,
   output logic             evt
);

   logic             seen_q;
   logic [CNT_W-1:0] last_q;
   logic             fresh;
   logic             hit;
   logic             at_zero;
   logic             at_ref0;
   logic             out_q;
   logic             nxt;

   // A counter value is evaluated once, in the first cycle it appears.
   assign fresh   = active & (~seen_q | (cnt != last_q));
   assign hit     = fresh & (cnt == own_val);
   assign at_zero = fresh & (cnt == '0);
   assign at_ref0 = fresh & (cnt == ref0_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else begin
         seen_q <= 1'b1;
         last_q <= cnt;
      end
   end

   always_comb begin
      nxt = out_q;
      case (act)
         ACT_SET: if (hit) nxt = 1'b1;
         ACT_CLR: if (hit) nxt = 1'b0;
         ACT_TGL: if (hit) nxt = ~out_q;
         ACT_DIR_SET: begin
            if (updown) begin
               if (hit) nxt = ~cnt_down;
            end else if (hit) begin
               nxt = 1'b1;
            end else if (at_zero) begin
               nxt = 1'b0;
            end
         end
         ACT_DIR_CLR: begin
            if (updown) begin
               if (hit) nxt = cnt_down;
            end else if (hit) begin
               nxt = 1'b0;
            end else if (at_zero) begin
               nxt = 1'b1;
            end
         end
         ACT_WIN_SET: begin
            if (hit)          nxt = 1'b1;
            else if (at_ref0) nxt = 1'b0;
         end
         ACT_WIN_CLR: begin
            if (hit)          nxt = 1'b0;
            else if (at_ref0) nxt = 1'b1;
         end
         default: nxt = out_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_q <= 1'b0;
      else if (init) out_q <= 1'b0;
      else           out_q <= nxt;
   end

   assign out = out_q;
   assign evt = hit & (act != ACT_INIT);

endmodule

// File: rtl/tcc_regs.sv
module tcc_regs
   import tcc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic [1:0]          rd_sel,
   output logic [BYTE_W-1:0]   rd_data,
   input  logic [2*BYTE_W-1:0] cnt,
   input  logic                cap_evt,
   output ctrl_t               ctrl,
   output logic [2*BYTE_W-1:0] val,
   output logic                init_pulse
);

   localparam int VAL_W = 2 * BYTE_W;

   generate
      if (BYTE_W < CTRL_W) begin : g_bad_byte
         $error("tcc_regs: BYTE_W must hold the control byte");
      end
   endgenerate

   ctrl_t              ctrl_q;
   ctrl_t              ctrl_wr;
   logic [BYTE_W-1:0]  lo_buf_q;
   logic [VAL_W-1:0]   val_q;
   logic [VAL_W-1:0]   pend_q;
   logic               pend_v_q;
   logic               wr_ctrl;
   logic               wr_lo;
   logic               wr_hi;
   logic               apply_pend;

   assign wr_ctrl    = wr_en & (rsel_e'(wr_sel) == SEL_CTRL);
   assign wr_lo      = wr_en & (rsel_e'(wr_sel) == SEL_LO);
   assign wr_hi      = wr_en & (rsel_e'(wr_sel) == SEL_HI);
   assign ctrl_wr    = ctrl_t'(wr_data[CTRL_W-1:0]);
   assign init_pulse = wr_ctrl & (ctrl_wr.act == ACT_INIT);
   assign apply_pend = ctrl_q.cmp_mode & pend_v_q & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (wr_ctrl) begin
         ctrl_q.alt_src  <= ctrl_wr.alt_src;
         ctrl_q.ie       <= ctrl_wr.ie;
         ctrl_q.cmp_mode <= ctrl_wr.cmp_mode;
         ctrl_q.edge_sel <= ctrl_wr.edge_sel;
         if (ctrl_wr.act != ACT_INIT) ctrl_q.act <= ctrl_wr.act;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_buf_q <= '0;
      else if (wr_lo) lo_buf_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q    <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else if (wr_hi) begin
         if (ctrl_q.cmp_mode) begin
            pend_q   <= {wr_data, lo_buf_q};
            pend_v_q <= 1'b1;
         end else begin
            val_q    <= {wr_data, lo_buf_q};
            pend_v_q <= 1'b0;
         end
      end else if (apply_pend) begin
         val_q    <= pend_q;
         pend_v_q <= 1'b0;
      end else if (cap_evt) begin
         val_q <= cnt;
      end
   end

   always_comb begin
      case (rsel_e'(rd_sel))
         SEL_CTRL: rd_data = BYTE_W'(ctrl_q);
         SEL_LO:   rd_data = val_q[BYTE_W-1:0];
         SEL_HI:   rd_data = val_q[VAL_W-1:BYTE_W];
         default:  rd_data = '0;
      endcase
   end

   assign ctrl = ctrl_q;
   assign val  = val_q;

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_SYNC    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*BYTE_W-1:0] cnt,
   input  logic                cnt_down,
   input  logic                updown_mode,
   input  logic [2*BYTE_W-1:0] ref0_val,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic [1:0]          rd_sel,
   output logic [BYTE_W-1:0]   rd_data,
   input  logic                cap_pin,
   input  logic                radio_evt,
   input  logic                flag_clr,
   output logic                cmp_out,
   output logic                irq
);

   localparam int CNT_W = 2 * BYTE_W;

   ctrl_t            ctrl;
   logic [CNT_W-1:0] val;
   logic             init_pulse;
   logic             cap_evt;
   logic             cmp_evt;
   logic             set_evt;
   logic             flag_q;
   logic             mode_c;
   logic             ie_c;
   act_e             act_c;
   edge_e            edge_c;

   assign mode_c = ctrl.cmp_mode;
   assign ie_c   = ctrl.ie;
   assign act_c  = ctrl.act;
   assign edge_c = ctrl.edge_sel;

   tcc_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .rd_sel    (rd_sel),
      .rd_data   (rd_data),
      .cnt       (cnt),
      .cap_evt   (cap_evt),
      .ctrl      (ctrl),
      .val       (val),
      .init_pulse(init_pulse)
   );

   tcc_capture #(.SYNC_STAGES(SYNC_STAGES), .ALT_SYNC(ALT_SYNC)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (cap_pin),
      .alt     (radio_evt),
      .use_alt (ctrl.alt_src),
      .edge_sel(edge_c),
      .enable  (~mode_c),
      .evt     (cap_evt)
   );

   tcc_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .cnt_down(cnt_down),
      .updown  (updown_mode),
      .own_val (val),
      .ref0_val(ref0_val),
      .act     (act_c),
      .active  (mode_c),
      .init    (init_pulse),
      .out     (cmp_out),
      .evt     (cmp_evt)
   );

   assign set_evt = cap_evt | cmp_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign irq = flag_q & ie_c;

endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [1:0]          wr_sel,
   input logic [BYTE_W-1:0]   wr_data,
   input logic [2*BYTE_W-1:0] cnt,
   input logic                mode_c,
   input logic                ie_c,
   input logic [2:0]          act_c,
   input logic [1:0]          edge_c,
   input logic [2*BYTE_W-1:0] val,
   input logic                cmp_out,
   input logic                irq,
   input logic                flag_clr,
   input logic                set_evt
);

   // R12
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ie_c);

   // R12
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !set_evt) |=> !irq);

   // R12
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt && ie_c && !(wr_en && wr_sel == 2'd0)) |=> irq);

   // R11
   staged_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_c) && (val != $past(val))) |-> ($past(cnt) == '0));

   // R9
   low_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && mode_c && cnt != '0) |=> $stable(val));

   // R8
   init_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && wr_data[5:3] == 3'b111) |=> (!cmp_out && act_c == $past(act_c)));

   // R3
   no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_c && edge_c == 2'd0 && !wr_en) |=> $stable(val));

endmodule

bind tcc_channel tcc_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .cnt     (cnt),
   .mode_c  (mode_c),
   .ie_c    (ie_c),
   .act_c   (act_c),
   .edge_c  (edge_c),
   .val     (val),
   .cmp_out (cmp_out),
   .irq     (irq),
   .flag_clr(flag_clr),
   .set_evt (set_evt)
);

// File: tb/sim_tcc_channel.sv
module sim_tcc_channel;

   localparam int CLK_PER = 10;
   localparam logic [15:0] CMP_VAL = 16'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt = '0;
   logic        cnt_down = 1'b0;
   logic        updown_mode = 1'b0;
   logic [15:0] ref0_val = 16'd9;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [7:0]  rd_data;
   logic        cap_pin = 1'b0;
   logic        radio_evt = 1'b0;
   logic        flag_clr = 1'b0;
   logic        cmp_out;
   logic        irq;

   int   checks = 0;
   int   errors = 0;
   logic exp_out;
   logic [15:0] prev_c;
   logic [2:0]  cur_act;

   always #(CLK_PER/2) clk = ~clk;

   tcc_channel u0 (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down),
      .updown_mode(updown_mode), .ref0_val(ref0_val), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .cap_pin(cap_pin), .radio_evt(radio_evt), .flag_clr(flag_clr),
      .cmp_out(cmp_out), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, want);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cnt = '0; cnt_down = 1'b0; wr_en = 1'b0;
      cap_pin = 1'b0; radio_evt = 1'b0; flag_clr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      prev_c = '0; exp_out = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      rd_sel = s;
      #1;
      d = rd_data;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(2'd1, lo);
      rd(2'd2, hi);
      v = {hi, lo};
   endtask

   task automatic pulse_clr();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   function automatic logic model_next(input logic [2:0] a, input logic [15:0] c,
                                       input logic dn, input logic fresh, input logic cur);
      logic m, z, r, n;
      m = fresh && (c == CMP_VAL);
      z = fresh && (c == 16'd0);
      r = fresh && (c == ref0_val);
      n = cur;
      case (a)
         3'd0: if (m) n = 1'b1;
         3'd1: if (m) n = 1'b0;
         3'd2: if (m) n = ~cur;
         3'd3: if (updown_mode) begin if (m) n = !dn; end
               else if (m) n = 1'b1; else if (z) n = 1'b0;
         3'd4: if (updown_mode) begin if (m) n = dn; end
               else if (m) n = 1'b0; else if (z) n = 1'b1;
         3'd5: if (m) n = 1'b1; else if (r) n = 1'b0;
         3'd6: if (m) n = 1'b0; else if (r) n = 1'b1;
         default: n = cur;
      endcase
      return n;
   endfunction

   task automatic step(input logic [15:0] c, input logic dn, input bit do_chk, input string req);
      @(negedge clk);
      cnt = c; cnt_down = dn;
      exp_out = model_next(cur_act, c, dn, c != prev_c, exp_out);
      prev_c = c;
      @(posedge clk);
      #1;
      if (do_chk) check(req, cmp_out, exp_out);
   endtask

   task automatic setup_cmp(input logic [2:0] a);
      cur_act = a;
      wr(2'd0, 8'h40);
      wr(2'd1, CMP_VAL[7:0]);
      wr(2'd2, CMP_VAL[15:8]);
      wr(2'd0, {2'b01, a, 1'b1, 2'b00});
   endtask

   task automatic run_cmp(input logic [2:0] a, input bit ud, input logic [15:0] r0);
      string req;
      req = (a < 3) ? "R5" : (a < 5) ? "R6" : "R7";
      do_reset();
      updown_mode = ud; ref0_val = r0;
      setup_cmp(a);
      if (ud) begin
         for (int c = 1; c <= 15; c++) step(16'(c), 1'b0, 1'b1, req);
         for (int c = 14; c >= 0; c--) step(16'(c), 1'b1, 1'b1, req);
         for (int c = 1; c <= 8; c++) step(16'(c), 1'b0, 1'b1, req);
      end else begin
         for (int c = 1; c <= 15; c++) step(16'(c), 1'b0, 1'b1, req);
         for (int c = 0; c <= 15; c++) step(16'(c), 1'b0, 1'b1, req);
         for (int c = 0; c <= 5; c++) step(16'(c), 1'b0, 1'b1, req);
      end
      check("R12 match raises irq", irq, 1'b1);
      pulse_clr();
      #1 check("R12 clear drops irq", irq, 1'b0);
   endtask

   task automatic run_cap(input bit src, input logic [1:0] e);
      logic [15:0] v, expv, a_val, b_val;
      bit rise_ok, fall_ok;
      rise_ok = (e == 2'd1) || (e == 2'd3);
      fall_ok = (e == 2'd2) || (e == 2'd3);
      a_val = 16'h1000 + 16'(e) * 16'h10 + 16'(src);
      b_val = a_val + 16'h2000;
      do_reset();
      wr(2'd0, {src, 1'b1, 3'b000, 1'b0, e});
      expv = 16'h0000;
      @(negedge clk); cnt = a_val;
      if (src) radio_evt = 1'b1; else cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      if (rise_ok) expv = a_val;
      rd16(v);
      check(src ? "R4 radio rise value" : "R3 rise value", v, expv);
      check(src ? "R4 radio rise irq" : "R3 rise irq", irq, rise_ok);
      pulse_clr();
      @(negedge clk); cnt = b_val;
      if (src) radio_evt = 1'b0; else cap_pin = 1'b0;
      repeat (5) @(negedge clk);
      if (fall_ok) expv = b_val;
      rd16(v);
      check(src ? "R4 radio fall value" : "R3 fall value", v, expv);
      check(src ? "R4 radio fall irq" : "R3 fall irq", irq, fall_ok);
      pulse_clr();
      @(negedge clk); cnt = b_val + 16'h0100;
      if (src) cap_pin = 1'b1; else radio_evt = 1'b1;
      repeat (5) @(negedge clk);
      if (src) cap_pin = 1'b0; else radio_evt = 1'b0;
      repeat (5) @(negedge clk);
      rd16(v);
      check("R4 unselected source value", v, expv);
      check("R4 unselected source irq", irq, 1'b0);
   endtask

   initial begin
      #(CLK_PER * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] v;
      cur_act = 3'd0; exp_out = 1'b0; prev_c = '0;

      // R1 reset state
      do_reset();
      rd(2'd0, b); check("R1 ctrl reset", b, 8'h40);
      rd(2'd1, b); check("R1 low reset", b, 8'h00);
      rd(2'd2, b); check("R1 high reset", b, 8'h00);
      check("R1 pin reset", cmp_out, 1'b0);
      check("R1 irq reset", irq, 1'b0);

      // R2 control readback and unused select
      wr(2'd0, 8'hA6);
      rd(2'd0, b); check("R2 ctrl readback", b, 8'hA6);
      rd(2'd3, b); check("R2 select 3 reads zero", b, 8'h00);

      // R9 / R10 buffered low byte, immediate in capture mode
      do_reset();
      wr(2'd1, 8'h34);
      rd16(v); check("R9 low held in buffer", v, 16'h0000);
      wr(2'd2, 8'h12);
      rd16(v); check("R10 capture-mode write", v, 16'h1234);

      // R11 staged update in compare mode
      @(negedge clk); cnt = 16'd7;
      wr(2'd0, 8'h44);
      wr(2'd1, 8'h78);
      wr(2'd2, 8'h56);
      repeat (3) @(negedge clk);
      rd16(v); check("R11 held until zero", v, 16'h1234);
      @(negedge clk); cnt = 16'd0;
      @(posedge clk); #1;
      rd16(v); check("R11 applied at zero", v, 16'h5678);

      // R5..R7 compare action sweep
      for (int a = 0; a < 7; a++) begin
         run_cmp(3'(a), 1'b0, 16'd9);
         run_cmp(3'(a), 1'b1, 16'd9);
      end
      // R7 own match over channel-zero match
      run_cmp(3'd5, 1'b0, CMP_VAL);
      run_cmp(3'd6, 1'b0, CMP_VAL);

      // R8 init action
      do_reset(); updown_mode = 1'b0; ref0_val = 16'd9;
      setup_cmp(3'd0);
      step(16'd4, 1'b0, 1'b0, "R8");
      step(16'd5, 1'b0, 1'b1, "R8 pin set before init");
      wr(2'd0, 8'h7C);
      check("R8 init drives pin low", cmp_out, 1'b0);
      rd(2'd0, b); check("R8 action kept", b, 8'h44);

      // R13 held counter fires once
      do_reset(); updown_mode = 1'b0;
      setup_cmp(3'd2);
      step(16'd4, 1'b0, 1'b1, "R13");
      for (int k = 0; k < 5; k++) step(16'd5, 1'b0, 1'b1, "R13 held match");
      check("R13 single toggle", cmp_out, 1'b1);

      // R3 / R4 capture sweep
      for (int s = 0; s < 2; s++)
         for (int e = 0; e < 4; e++)
            run_cap(1'(s), 2'(e));

      // R12 mask then enable
      do_reset();
      wr(2'd0, 8'h01);
      @(negedge clk); cnt = 16'h00AB; cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      check("R12 masked irq", irq, 1'b0);
      wr(2'd0, 8'h41);
      #1 check("R12 sticky flag after enable", irq, 1'b1);
      rd16(v); check("R3 masked capture value", v, 16'h00AB);
      pulse_clr();
      #1 check("R12 cleared", irq, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule